// File: doc/BRIEF.md
# Pulse Burst Modulator and PWM Timer

This block drives a single output pin from an 8-bit down counter and an 8-bit reload register, under three control bits. Depending on those bits the pin is released to normal I/O, toggles freely with a 50% duty cycle, produces one high pulse of programmed width each time an external 16-bit timer underflows, or passes a fixed number of clock pulses to the pin as a burst. Burst pulses come either from a fast clock input or from an internal clock at one tenth of the system clock rate.

Software programs the reload value and the control bits through a small write/read register port. Setting the run bit loads the counter from the reload register and starts it. In burst and variable-duty modes, hardware clears the run bit when the counter underflows. In variable-duty mode the run bit is also set by a strobe from the external timer. The timer itself lies outside the block and appears here only as that strobe.

Top module: `pulse_mod`

## Requirements
- R1: After reset the reload register and all control bits read 0, `pin_out` is 0 and `pin_drive` is 0.
- R2: Address 0 holds the reload value. Address 1 holds the control bits: bit 0 is run, bit 1 is clock/duty select, bit 2 is mode select. Bits 7:3 of address 1 read as 0 whatever was written to them.
- R3: A control write with bit 0 set loads the counter from the reload register and restarts the divide-by-ten phase. If a hardware underflow clear happens in the same cycle, the write wins and the run bit stays set.
- R4: With control = 3'b001, the pin goes high in the cycle after the write. It then toggles every (R+1)*10 cycles, where R is the reload value, until run is cleared.
- R5: With mode select = 1 and clock select = 0, the pin shows R+1 pulses, each 5 cycles high and 5 cycles low. The run bit then clears by itself and the pin stays low.
- R6: With mode select = 1 and clock select = 1, the pin follows `fast_clk` while run is set. Each falling edge of `fast_clk` counts one pulse, so R+1 pulses pass and R = 255 gives 256 pulses. After the last pulse, run clears and the pin stays low.
- R7: With control = 3'b010, a `timer_uf` strobe sets run and drives the pin high for (R+1)*10 cycles. The pin then goes low and run clears.
- R8: A `timer_uf` strobe has no effect unless mode select = 0 and clock select = 1.
- R9: A control write that clears run drives the pin low from the next cycle, in every mode.
- R10: `pin_drive` is 1 whenever any control bit is set. When `pin_drive` is 0, `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 reload, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 reload, 1 control |
| rd_data | output | 8 | Read data |
| fast_clk | input | 1 | Fast pulse source for burst mode |
| timer_uf | input | 1 | External timer underflow strobe |
| pin_out | output | 1 | Pin level |
| pin_drive | output | 1 | Block owns the pin |

## Verification
Some rules hold on every cycle, and the checker watches those. The pin stays quiet when the block does not own it. Burst output is gated off once run is low. A software stop silences the pin on the next cycle. Run only rises after a software set or an accepted timer strobe. A stray strobe cannot start an idle counter.

Other behaviour depends on counting over long windows, and only the directed scenarios can show it. This includes exact pulse counts, including the 256-pulse limit, and the toggle half-period and variable pulse width as multiples of ten cycles. It also includes the same-cycle race between a software set and an underflow clear.

// File: rtl/pulse_mod.sv
module pulse_mod #(
  parameter int WIDTH = 8,
  parameter int DIV   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic             fast_clk,
  input  logic             timer_uf,
  output logic             pin_out,
  output logic             pin_drive
);
  localparam int DW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [WIDTH-1:0] reload_q, cnt_q;
  logic [DW-1:0]    div_q;
  logic             run_q, sel_q, mode_q, tog_q, fast_prev_q;

  wire ctrl_wr   = wr_en & wr_addr;
  wire sw_start  = ctrl_wr & wr_data[0];
  wire duty_mode = ~mode_q & sel_q;
  wire hw_start  = duty_mode & timer_uf & ~ctrl_wr;
  wire load      = sw_start | hw_start;

  wire tc_tick = (div_q == DW'(DIV - 1));
  wire tc_fall = (div_q == DW'(HALF - 1));
  wire step    = mode_q ? (sel_q ? (fast_prev_q & ~fast_clk) : tc_fall) : tc_tick;
  wire uflow   = run_q & step & (cnt_q == '0);
  wire src     = sel_q ? fast_clk : (div_q < DW'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q    <= '0;
      cnt_q       <= '0;
      div_q       <= '0;
      run_q       <= 1'b0;
      sel_q       <= 1'b0;
      mode_q      <= 1'b0;
      tog_q       <= 1'b0;
      fast_prev_q <= 1'b0;
    end else begin
      fast_prev_q <= fast_clk;
      if (wr_en && !wr_addr) reload_q <= wr_data;

      if (ctrl_wr) begin
        run_q  <= wr_data[0];
        sel_q  <= wr_data[1];
        mode_q <= wr_data[2];
      end else if (hw_start) begin
        run_q <= 1'b1;
      end else if (uflow && (mode_q || sel_q)) begin
        run_q <= 1'b0;
      end

      if (load || tc_tick) div_q <= '0;
      else                 div_q <= div_q + 1'b1;

      if (load)                cnt_q <= reload_q;
      else if (run_q && step)  cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;

      if (load)                              tog_q <= 1'b1;
      else if (uflow && !mode_q && !sel_q)   tog_q <= ~tog_q;
    end
  end

  assign pin_out   = run_q & (mode_q ? src : (sel_q | tog_q));
  assign pin_drive = run_q | sel_q | mode_q;
  assign rd_data   = rd_addr ? WIDTH'({mode_q, sel_q, run_q}) : reload_q;
endmodule

// File: rtl/pulse_mod_chk.sv
module pulse_mod_chk #(
  parameter int WIDTH = 8,
  parameter int DIV   = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [WIDTH-1:0] wr_data,
  input logic             timer_uf,
  input logic             run,
  input logic             sel,
  input logic             mode,
  input logic [$clog2(DIV)-1:0] div,
  input logic             pin_out,
  input logic             pin_drive
);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_drive |-> !pin_out);

  p_burst_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !run) |-> !pin_out);

  p_sw_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && !wr_data[0]) |=> !pin_out);

  p_run_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(wr_en && wr_addr && wr_data[0]) ||
                    $past(timer_uf && !mode && sel)));

  p_stray_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_uf && !run && !(!mode && sel) && !(wr_en && wr_addr)) |=> !run);

  p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    div < ($clog2(DIV))'(DIV));
endmodule

bind pulse_mod pulse_mod_chk #(.WIDTH(WIDTH), .DIV(DIV)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .timer_uf(timer_uf), .run(run_q), .sel(sel_q), .mode(mode_q), .div(div_q),
  .pin_out(pin_out), .pin_drive(pin_drive)
);

// File: tb/pulse_mod_tb.sv
module pulse_mod_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b1;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       fast_clk = 1'b0, timer_uf = 1'b0;
  logic       pin_out, pin_drive;
  int         errors = 0, checks = 0, cycles = 0;

  pulse_mod dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .fast_clk(fast_clk), .timer_uf(timer_uf),
    .pin_out(pin_out), .pin_drive(pin_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (pin_out == lvl && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic count_burst(input bit use_fast, output int pulses);
    logic prev = 1'b0;
    pulses = 0;
    for (int k = 0; k < 4000; k++) begin
      if (use_fast) fast_clk = (k % 4) < 2;
      #1;
      if (pin_out && !prev) pulses++;
      prev = pin_out;
      if (!rd_data[0] && !pin_out) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rd_addr = 1'b0; #1;
    chk(rd_data == 8'h00, "R1 reload", rd_data, 0);
    rd_addr = 1'b1; #1;
    chk(rd_data == 8'h00, "R1 ctrl", rd_data, 0);
    chk(pin_out == 1'b0 && pin_drive == 1'b0, "R1 pin", {pin_out, pin_drive}, 0);
  endtask

  task automatic t_regs();
    wr(1'b0, 8'hA5);
    rd_addr = 1'b0; #1;
    chk(rd_data == 8'hA5, "R2 reload readback", rd_data, 8'hA5);
    rd_addr = 1'b1;
    wr(1'b1, 8'hFC); #1;
    chk(rd_data == 8'h04, "R2 ctrl high bits", rd_data, 8'h04);
    chk(pin_drive == 1'b1 && pin_out == 1'b0, "R10 drive no run", {pin_drive, pin_out}, 2);
    wr(1'b1, 8'h00); #1;
    chk(pin_drive == 1'b0, "R10 released", pin_drive, 0);
  endtask

  task automatic t_half_duty();
    int n;
    wr(1'b0, 8'd2);
    wr(1'b1, 8'h01);
    measure(1'b1, n); chk(n == 30, "R4 first high", n, 30);
    measure(1'b0, n); chk(n == 30, "R4 low half", n, 30);
    measure(1'b1, n); chk(n == 30, "R4 second high", n, 30);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h00); #1;
    chk(pin_out == 1'b0, "R9 stop half duty", pin_out, 0);
  endtask

  task automatic t_burst_slow();
    int p, n;
    wr(1'b0, 8'd3);
    wr(1'b1, 8'h04);
    wr(1'b1, 8'h05);
    measure(1'b1, n); chk(n == 5, "R5 pulse high", n, 5);
    measure(1'b0, n); chk(n == 5, "R5 pulse low", n, 5);
    wr(1'b1, 8'h05);
    count_burst(1'b0, p);
    chk(p == 4, "R5 pulse count", p, 4);
    chk(rd_data[0] == 1'b0, "R5 run self clear", rd_data[0], 0);
    repeat (20) @(negedge clk);
    chk(pin_out == 1'b0 && pin_drive == 1'b1, "R5 stays low", pin_out, 0);
  endtask

  task automatic t_burst_fast(input logic [7:0] r, input int exp);
    int p, extra;
    fast_clk = 1'b0;
    wr(1'b0, r);
    wr(1'b1, 8'h07);
    count_burst(1'b1, p);
    chk(p == exp, "R6 fast pulse count", p, exp);
    extra = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); fast_clk = (k % 4) < 2; #1;
      if (pin_out) extra++;
    end
    fast_clk = 1'b0;
    chk(extra == 0, "R6 quiet after burst", extra, 0);
  endtask

  task automatic t_stop_burst();
    wr(1'b0, 8'd9);
    wr(1'b1, 8'h05);
    repeat (3) @(negedge clk);
    wr(1'b1, 8'h04); #1;
    chk(pin_out == 1'b0, "R9 stop burst", pin_out, 0);
    repeat (12) @(negedge clk);
    chk(pin_out == 1'b0 && rd_data[0] == 1'b0, "R9 stays stopped", pin_out, 0);
  endtask

  task automatic t_var_duty();
    int n;
    wr(1'b0, 8'd4);
    wr(1'b1, 8'h02); #1;
    chk(pin_out == 1'b0 && pin_drive == 1'b1, "R7 armed low", pin_out, 0);
    timer_uf = 1'b1; @(negedge clk); timer_uf = 1'b0;
    measure(1'b1, n); chk(n == 50, "R7 pulse width", n, 50);
    chk(rd_data[0] == 1'b0, "R7 run cleared", rd_data[0], 0);
    repeat (30) @(negedge clk);
    chk(pin_out == 1'b0, "R7 low until strobe", pin_out, 0);
  endtask

  task automatic t_race();
    int n;
    wr(1'b0, 8'd0);
    wr(1'b1, 8'h02);
    timer_uf = 1'b1; @(negedge clk); timer_uf = 1'b0;
    repeat (9) @(negedge clk);
    wr(1'b1, 8'h03); #1;
    chk(rd_data[0] == 1'b1 && pin_out == 1'b1, "R3 software set wins", rd_data[0], 1);
    measure(1'b1, n); chk(n == 10, "R3 reload after race", n, 10);
  endtask

  task automatic t_ignore_strobe();
    wr(1'b1, 8'h00);
    timer_uf = 1'b1; @(negedge clk); timer_uf = 1'b0; #1;
    chk(rd_data[0] == 1'b0 && pin_out == 1'b0, "R8 idle ignores strobe", rd_data[0], 0);
    wr(1'b1, 8'h04);
    timer_uf = 1'b1; @(negedge clk); timer_uf = 1'b0; #1;
    chk(rd_data[0] == 1'b0 && pin_out == 1'b0, "R8 burst ignores strobe", rd_data[0], 0);
    wr(1'b1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_half_duty();
    t_burst_slow();
    t_burst_fast(8'd5, 6);
    t_burst_fast(8'd255, 256);
    t_stop_burst();
    t_var_duty();
    t_race();
    t_ignore_strobe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule